// File: doc/BRIEF.md
# Multiplexed-Address Bit Memory Emulator

This block is a synthesizable stand-in for a 65,536-word by 1-bit dynamic memory that has a strobed, multiplexed address interface. A fast system clock samples the memory-side pins: an 8-bit shared address bus, an active-low row strobe, an active-low column strobe, an active-low write enable and one data-in bit. The block drives one data-out bit and a data-out enable. The enable stands in for the high-impedance state of a real pin.

A falling row strobe captures the row half of the address. A falling column strobe captures the column half and starts an access. The column strobe can be pulsed several times under one row strobe to reach other bits of the open row. The way the write enable lines up with the column strobe decides the cycle type. If write is already low, the cycle is a silent write. If write falls later, the stored bit is shown first and then overwritten. Refresh and retention are not modelled. A row-only strobe cycle is accepted and leaves both the output and the contents untouched. A sticky flag reports a column strobe that falls while no row is open.

Top module: `mux_dram_emu`

## Requirements
- R1: After reset, `doutEn` and `errFlag` are 0.
- R2: The stored bit is selected by the 16-bit address {row, column}. The row is the bus value sampled when `rasN` falls, and the column is the bus value sampled when `casN` falls. A read is a falling `casN` with `weN` high and `rasN` low. In a read, `dout` holds the addressed bit and `doutEn` is 1 from the third rising clock edge after the column strobe falls.
- R3: When `weN` is already low as `casN` falls, `din` is stored at the addressed bit and `doutEn` stays 0 for the whole cycle.
- R4: When `weN` falls while `casN` and `rasN` are low and the cycle began as a read, `dout` keeps showing the old bit with `doutEn` at 1, and `din` is written to the same address.
- R5: While `rasN` stays low, each new `casN` pulse with a new column accesses another bit of the same row.
- R6: `doutEn` returns to 0 by the second rising edge after `casN` goes high.
- R7: While `casN` is held low, `rasN` may be raised and lowered again any number of times. Through all of it, `dout` and `doutEn` keep the data of the last read.
- R8: Strobing `rasN` while `casN` stays high never raises `doutEn` and leaves the stored bits unchanged.
- R9: A fall of `casN` while `rasN` is high sets `errFlag` by the second rising edge after the fall. `errFlag` then stays 1 until reset.
- R10: `doutEn` only rises while `casN` is low. While `doutEn` stays 1, `dout` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Multiplexed row/column address |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit |
| doutEn | output | 1 | Output drive enable (0 = high impedance) |
| errFlag | output | 1 | Sticky strobe-order violation flag |

## Verification
Strobe edges count from the rising clock edge that first samples the new pin level. A column fall gives valid read data on the third edge. A column rise turns the output off on the second edge. An order error shows on the second edge. A write is in the array two edges after its strobe is sampled. The bench drives pins on falling clock edges. Each expectation is queued with the clock count at which it falls due. A monitor pops and compares each item on the falling edge of that exact cycle, so every result is checked in its own cycle and never merely "eventually".

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;
  // control-to-datapath strobes, one per clock
  typedef struct packed {
    logic rowLoad;   // capture row half of the address
    logic issue;     // start an array word read
    logic colLoad;   // issue takes its column from the bus (else held column)
    logic memWrite;  // commit merged word for the pending access
    logic outLoad;   // present the pending read bit on the output
    logic outOff;    // column strobe released: drop the output
    logic wrBit;     // bit to be merged on memWrite
  } ctlStrobes_t;
endpackage

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mux_dram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              din,
  output logic [ADDR_W-1:0] addrS,
  output ctlStrobes_t       strobes,
  output logic              errFlag
);
  localparam int PIN_W = ADDR_W + 4;

  logic [PIN_W-1:0] pinStage [SYNC_STAGES];
  logic [PIN_W-1:0] pinNow;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSample
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pinStage[g] <= {{ADDR_W{1'b0}}, 4'b1110};
        else if (g == 0) pinStage[g] <= {addr, rasN, casN, weN, din};
        else pinStage[g] <= pinStage[g-1];
      end
    end
  endgenerate

  assign pinNow = pinStage[SYNC_STAGES-1];

  logic rasQ, casQ, weQ, dinQ;
  assign addrS = pinNow[PIN_W-1:4];
  assign rasQ  = pinNow[3];
  assign casQ  = pinNow[2];
  assign weQ   = pinNow[1];
  assign dinQ  = pinNow[0];

  logic rasP, casP, weP;
  logic openCyc, wroteCyc, pendValid, pendWrite, wrBitR;

  logic rasFall, casFall, casRise, weFall, startAcc, lateWr, issue;
  assign rasFall  = rasP & ~rasQ;
  assign casFall  = casP & ~casQ;
  assign casRise  = ~casP & casQ;
  assign weFall   = weP & ~weQ;
  assign startAcc = casFall & ~rasQ;
  assign lateWr   = weFall & ~casQ & ~casFall & ~rasQ & openCyc & ~wroteCyc;
  assign issue    = startAcc | lateWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasP      <= 1'b1;
      casP      <= 1'b1;
      weP       <= 1'b1;
      openCyc   <= 1'b0;
      wroteCyc  <= 1'b0;
      pendValid <= 1'b0;
      pendWrite <= 1'b0;
      wrBitR    <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      rasP      <= rasQ;
      casP      <= casQ;
      weP       <= weQ;
      pendValid <= issue;
      pendWrite <= startAcc ? ~weQ : 1'b1;
      if (issue) wrBitR <= dinQ;
      if (startAcc) begin
        openCyc  <= 1'b1;
        wroteCyc <= ~weQ;
      end else if (casRise) begin
        openCyc  <= 1'b0;
        wroteCyc <= 1'b0;
      end else if (lateWr) begin
        wroteCyc <= 1'b1;
      end
      if (casFall & rasQ) errFlag <= 1'b1;
    end
  end

  always_comb begin
    strobes.rowLoad  = rasFall;
    strobes.issue    = issue;
    strobes.colLoad  = startAcc;
    strobes.memWrite = pendValid & pendWrite;
    strobes.outLoad  = pendValid & ~pendWrite;
    strobes.outOff   = casRise;
    strobes.wrBit    = wrBitR;
  end
endmodule

// File: rtl/mux_dram_path.sv
module mux_dram_path
  import mux_dram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrS,
  input  ctlStrobes_t       strobes,
  output logic              dout,
  output logic              doutEn
);
  localparam int FULL_W = 2 * ADDR_W;
  localparam int SEL_W  = $clog2(WORD_W);
  localparam int IDX_W  = FULL_W - SEL_W;
  localparam int DEPTH  = 2 ** IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rowReg, colReg;
  logic [IDX_W-1:0]  pendIdx;
  logic [SEL_W-1:0]  pendSel;
  logic [WORD_W-1:0] ramQ, mergedWord;
  logic [FULL_W-1:0] reqAddr;

  assign reqAddr = strobes.colLoad ? {rowReg, addrS} : {rowReg, colReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg  <= '0;
      colReg  <= '0;
      pendIdx <= '0;
      pendSel <= '0;
      dout    <= 1'b0;
      doutEn  <= 1'b0;
    end else begin
      if (strobes.rowLoad) rowReg <= addrS;
      if (strobes.colLoad) colReg <= addrS;
      if (strobes.issue) begin
        pendIdx <= reqAddr[FULL_W-1:SEL_W];
        pendSel <= reqAddr[SEL_W-1:0];
      end
      if (strobes.outLoad) dout <= ramQ[pendSel];
      if (strobes.outOff) doutEn <= 1'b0;
      else if (strobes.outLoad) doutEn <= 1'b1;
    end
  end

  always_comb begin
    mergedWord = ramQ;
    mergedWord[pendSel] = strobes.wrBit;
  end

  // word-wide array: one read port, one write port
  always_ff @(posedge clk) begin
    if (strobes.issue) ramQ <= mem[reqAddr[FULL_W-1:SEL_W]];
    if (strobes.memWrite) mem[pendIdx] <= mergedWord;
  end
endmodule

// File: rtl/mux_dram_emu.sv
module mux_dram_emu
  import mux_dram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              din,
  output logic              dout,
  output logic              doutEn,
  output logic              errFlag
);
  ctlStrobes_t       strobes;
  logic [ADDR_W-1:0] addrS;

  mux_dram_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rasN(rasN), .casN(casN),
    .weN(weN), .din(din), .addrS(addrS), .strobes(strobes), .errFlag(errFlag)
  );

  mux_dram_path #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_path (
    .clk(clk), .rstN(rstN), .addrS(addrS), .strobes(strobes),
    .dout(dout), .doutEn(doutEn)
  );
endmodule

// File: rtl/mux_dram_emu_chk.sv
module mux_dram_emu_chk (
  input logic clk,
  input logic rstN,
  input logic casN,
  input logic dout,
  input logic doutEn,
  input logic errFlag
);
  // R6
  off_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (casN && $past(casN) && $past(casN, 2)) |-> !doutEn);

  // R10
  enable_rise_cas_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn) |-> !casN);

  // R10 R7
  held_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(doutEn) && doutEn) |-> $stable(dout));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(errFlag) |-> errFlag);

  // R1
  always_comb begin
    if (!rstN) reset_quiet_chk: assert (!doutEn && !errFlag);
  end
endmodule

bind mux_dram_emu mux_dram_emu_chk i_chk (
  .clk(clk), .rstN(rstN), .casN(casN), .dout(dout),
  .doutEn(doutEn), .errFlag(errFlag)
);

// File: tb/test_mux_dram_emu.sv
module test_mux_dram_emu;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, din = 1'b0;
  logic dout, doutEn, errFlag;

  mux_dram_emu i_mux_dram_emu (
    .clk(clk), .rstN(rstN), .addr(addr), .rasN(rasN), .casN(casN),
    .weN(weN), .din(din), .dout(dout), .doutEn(doutEn), .errFlag(errFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int    due;
    bit    chkD;
    bit    d;
    bit    oe;
    bit    err;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit expErr = 1'b0;
  bit done = 1'b0;
  bit model [int];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due items on the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (doutEn !== it.oe || errFlag !== it.err || (it.chkD && dout !== it.d)) begin
        errors++;
        $display("FAIL %s cyc=%0d: dout=%b doutEn=%b errFlag=%b expected dout=%b doutEn=%b errFlag=%b",
                 it.tag, cyc, dout, doutEn, errFlag, it.d, it.oe, it.err);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(int dly, bit chkD, bit d, bit oe, string tag);
    item_t it;
    it.due = cyc + dly; it.chkD = chkD; it.d = d; it.oe = oe; it.err = expErr; it.tag = tag;
    q.push_back(it);
  endtask

  function automatic bit pat(logic [7:0] r, logic [7:0] c);
    return c[0] ^ c[2] ^ r[1] ^ 1'b1;
  endfunction

  task automatic openRow(logic [7:0] r);
    addr = r; rasN = 1'b0; step(2);
  endtask

  task automatic closeRow();
    rasN = 1'b1; step(2);
  endtask

  task automatic earlyWrite(logic [7:0] r, logic [7:0] c, bit b);
    weN = 1'b0; din = b; addr = c; casN = 1'b0;
    model[{r, c}] = b;
    pushExp(1, 0, 0, 0, "R3 early write quiet");
    pushExp(3, 0, 0, 0, "R3 early write quiet");
    step(4);
    casN = 1'b1; weN = 1'b1; step(3);
  endtask

  task automatic doRead(logic [7:0] r, logic [7:0] c, string tag);
    addr = c; casN = 1'b0; din = ~model[{r, c}];
    pushExp(3, 1, model[{r, c}], 1, tag);
    step(4);
    casN = 1'b1;
    pushExp(2, 0, 0, 0, "R6 output off");
    step(3);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    pushExp(1, 0, 0, 0, "R1 reset state");
    step(2);

    // R3 early writes across a row, incl. word edges
    openRow(8'h3C);
    for (int c = 0; c < 8; c++) earlyWrite(8'h3C, 8'(c), pat(8'h3C, 8'(c)));
    earlyWrite(8'h3C, 8'h1F, 1'b1);
    earlyWrite(8'h3C, 8'h20, 1'b0);
    earlyWrite(8'h3C, 8'hFF, 1'b1);
    // R5 page reads in the same open row
    for (int c = 7; c >= 0; c--) doRead(8'h3C, 8'(c), "R5 page read");
    doRead(8'h3C, 8'h1F, "R2 read word edge");
    doRead(8'h3C, 8'h20, "R2 read word edge");
    doRead(8'h3C, 8'hFF, "R2 read top column");
    closeRow();

    // R2 other row, same columns
    openRow(8'hC3);
    earlyWrite(8'hC3, 8'h05, ~model[{8'h3C, 8'h05}]);
    doRead(8'hC3, 8'h05, "R2 row select");
    closeRow();
    openRow(8'h3C);
    doRead(8'h3C, 8'h05, "R2 row kept");

    // R4 read-modify-write on column 1
    begin
      bit oldB, newB;
      oldB = model[{8'h3C, 8'h01}];
      newB = ~oldB;
      weN = 1'b1; addr = 8'h01; casN = 1'b0;
      pushExp(3, 1, oldB, 1, "R4 old bit first");
      step(4);
      weN = 1'b0; din = newB; addr = 8'h77;
      pushExp(3, 1, oldB, 1, "R4 old bit held during write");
      step(4);
      casN = 1'b1; weN = 1'b1;
      pushExp(2, 0, 0, 0, "R6 off after rmw");
      step(3);
      model[{8'h3C, 8'h01}] = newB;
      doRead(8'h3C, 8'h01, "R4 new bit stored");
    end

    // R7 hidden refresh hold
    addr = 8'h02; casN = 1'b0;
    pushExp(3, 1, model[{8'h3C, 8'h02}], 1, "R7 initial read");
    step(4);
    rasN = 1'b1; step(2);
    addr = 8'h11; rasN = 1'b0; step(2);
    pushExp(1, 1, model[{8'h3C, 8'h02}], 1, "R7 held across refresh");
    rasN = 1'b1; step(2);
    addr = 8'h3C; rasN = 1'b0; step(2);
    pushExp(1, 1, model[{8'h3C, 8'h02}], 1, "R7 held after second refresh");
    step(1);
    casN = 1'b1;
    pushExp(2, 0, 0, 0, "R6 off after hidden refresh");
    step(3);
    closeRow();

    // R8 row-only refresh cycles
    for (int r = 0; r < 4; r++) begin
      addr = 8'(r * 61); rasN = 1'b0; din = 1'b1; weN = 1'b0;
      pushExp(2, 0, 0, 0, "R8 refresh quiet");
      step(3);
      rasN = 1'b1; weN = 1'b1; step(2);
    end
    openRow(8'h3C);
    doRead(8'h3C, 8'h03, "R8 contents kept");
    doRead(8'h3C, 8'hFF, "R8 contents kept");
    closeRow();

    // R9 column strobe with no row open
    addr = 8'h00; casN = 1'b0;
    expErr = 1'b1;
    pushExp(2, 0, 0, 0, "R9 error set");
    step(3);
    casN = 1'b1;
    pushExp(3, 0, 0, 0, "R9 error sticky");
    step(4);
    openRow(8'hC3);
    doRead(8'hC3, 8'h05, "R9 flag kept during read");
    closeRow();

    step(4);
    done = 1'b1;
    finishRun();
  end
endmodule